// File: doc/BRIEF.md
# Resource Descriptor Stream Parser

This block walks a byte stream of plug-and-play resource data, presented one byte per cycle under a valid/ready handshake, and cuts it into items. Each item begins with one tag byte. Bit 7 of the tag tells the parser the item type. A small item keeps its name and its payload length inside the tag. A large item keeps only its name in the tag, and a two-byte length field follows the tag before the payload.

For every item the parser emits a one-cycle header strobe that carries the type, the name and the payload length. Payload bytes then come out one at a time, each with its offset inside the item. Names that are reserved set a sticky error flag, and their payload is consumed without being presented. The end tag stops the parser once its payload has been consumed. From then on the input is refused until a synchronous restart or a reset.

The block does not look inside the descriptors, check the checksum or handle the card identifier. Downstream logic uses the header strobe and the tagged payload bytes to assemble whichever descriptors it cares about.

Top module: `res_stream_parser`

## Requirements
- R1: After reset (`rst_n` low at a clock edge) `done`, `rsvd_err`, `item_start` and `pay_valid` are 0, every item and payload field is 0, and `in_ready` is 1.
- R2: A tag with bit 7 = 0 is a small item. Its name is bits [6:3], which appear zero-extended on `item_name`, and its payload length is bits [2:0]. One cycle after the tag is accepted, `item_start` pulses with `item_large` = 0 and `item_len` equal to that length.
- R3: A tag with bit 7 = 1 is a large item whose name is bits [6:0]. The next two accepted bytes are the length, low byte first. `item_start` pulses one cycle after the high length byte is accepted, with `item_large` = 1 and `item_len` = {high, low}.
- R4: Every payload byte of a non-reserved item appears on `pay_data` with `pay_valid` high one cycle after it is accepted. `pay_offset` is 0 for the first byte of the item and rises by one for each following byte.
- R5: An item whose length is zero (small length 0, or large length 0x0000) has no payload. The next accepted byte is taken as a new tag.
- R6: Small names 0xA to 0xD, and large names outside 0x01 to 0x06, are reserved. Such an item sets `rsvd_err` in the same cycle as its `item_start`, and `rsvd_err` stays set until restart or reset. Its payload is consumed by length without any `pay_valid`.
- R7: Small name 0xF is the end tag, and its payload length comes from its tag. `done` rises one cycle after the last byte of that payload is accepted, which is the same cycle that byte is shown on `pay_valid`. With length 0, `done` rises one cycle after the tag is accepted.
- R8: While `done` is 1, `in_ready` is 0 and the input has no effect on any output, until restart or reset.
- R9: `restart` high at a clock edge returns the parser to the tag state and clears `done`, `rsvd_err` and all item and payload outputs. `in_ready` is 0 while `restart` is high, so a byte presented in that cycle is not consumed.
- R10: A byte is consumed only at an edge where `in_valid` and `in_ready` are both 1. Idle cycles inside an item or its length field change nothing.
- R11: `item_start` and `pay_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Synchronous restart to the tag state |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser can take a byte |
| item_start | output | 1 | One-cycle header strobe |
| item_large | output | 1 | 1 = large item, 0 = small item |
| item_name | output | 7 | Item name (small names zero-extended) |
| item_len | output | 16 | Payload length in bytes |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pay_offset | output | 16 | Offset of the payload byte within its item |
| done | output | 1 | End tag fully consumed |
| rsvd_err | output | 1 | Sticky flag: a reserved item name was seen |

## Verification
Two events can land in the same cycle: the output of the end tag's final payload byte, and the rise of `done`. The bench sends an end tag with a one-byte checksum directly after other items. It then checks that the cycle showing the byte on `pay_valid` is also the first cycle with `done` high and `in_ready` low. It also checks that bytes presented after that point leave every output unchanged. A zero-length end tag covers the other case, where `done` must rise together with the header strobe and no payload strobe appears.

// File: rtl/rsp_pkg.sv
// Package: shared constants and types for the resource stream parser.
// Assumes byte-wide input and a large-item length field exactly two bytes wide.
package rsp_pkg;
    localparam int BYTE_W  = 8;
    localparam int LEN_W   = 2 * BYTE_W;
    localparam int NAME_W  = BYTE_W - 1;
    localparam int SNAME_W = 4;
    localparam int SLEN_W  = 3;

    localparam logic [SNAME_W-1:0] SMALL_END_NAME = 4'hF;
    localparam logic [SNAME_W-1:0] SMALL_RSV_LO   = 4'hA;
    localparam logic [SNAME_W-1:0] SMALL_RSV_HI   = 4'hD;
    localparam logic [NAME_W-1:0]  LARGE_DEF_LO   = 7'h01;
    localparam logic [NAME_W-1:0]  LARGE_DEF_HI   = 7'h06;

    typedef enum logic [2:0] {
        ST_TAG,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_PAYLOAD,
        ST_DONE
    } parse_state_e;
endpackage

// File: rtl/rsp_tag_decode.sv
// Module: rsp_tag_decode
// Purely combinational split of one tag byte into type, name, small length,
// end marker and reserved-name flag. Assumes the byte really is a tag; the
// caller decides that from its own state.
module rsp_tag_decode
    import rsp_pkg::*;
(
    input  logic [BYTE_W-1:0] tag,
    output logic              is_large,
    output logic [NAME_W-1:0] name,
    output logic [LEN_W-1:0]  small_len,
    output logic              is_end,
    output logic              is_rsvd
);
    logic [SNAME_W-1:0] sname;

    // Field extraction and name classification.
    always_comb begin
        is_large  = tag[BYTE_W-1];
        sname     = tag[BYTE_W-2 -: SNAME_W];
        small_len = {{(LEN_W-SLEN_W){1'b0}}, tag[SLEN_W-1:0]};
        if (is_large) begin
            name    = tag[NAME_W-1:0];
            is_end  = 1'b0;
            is_rsvd = (name < LARGE_DEF_LO) || (name > LARGE_DEF_HI);
        end else begin
            name    = {{(NAME_W-SNAME_W){1'b0}}, sname};
            is_end  = (sname == SMALL_END_NAME);
            is_rsvd = (sname >= SMALL_RSV_LO) && (sname <= SMALL_RSV_HI);
        end
    end
endmodule

// File: rtl/rsp_ctrl.sv
// Module: rsp_ctrl
// Parse state machine (tag, length low, length high, payload, done). It
// counts the remaining payload bytes and the offset, and produces one-cycle
// header and payload events for the byte accepted this cycle. Assumes at
// most one byte is accepted per cycle; restart outranks any input.
module rsp_ctrl
    import rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              dec_large,
    input  logic [NAME_W-1:0] dec_name,
    input  logic [LEN_W-1:0]  dec_small_len,
    input  logic              dec_end,
    input  logic              dec_rsvd,
    output logic              in_ready,
    output logic              hdr_evt,
    output logic              hdr_large,
    output logic [NAME_W-1:0] hdr_name,
    output logic [LEN_W-1:0]  hdr_len,
    output logic              hdr_rsvd,
    output logic              pay_evt,
    output logic [BYTE_W-1:0] pay_byte,
    output logic [LEN_W-1:0]  pay_off,
    output logic              done
);
    parse_state_e      state_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  off_q;
    logic [BYTE_W-1:0] len_lo_q;
    logic [NAME_W-1:0] name_q;
    logic              rsvd_q;
    logic              end_q;
    logic              accept;
    logic [LEN_W-1:0]  wide_len;

    assign in_ready = (state_q != ST_DONE) && !restart;
    assign accept   = in_valid && in_ready;
    assign wide_len = {in_data, len_lo_q};
    assign done     = (state_q == ST_DONE);
    assign pay_byte = in_data;
    assign pay_off  = off_q;

    // Event generation for the byte accepted in this cycle.
    always_comb begin
        hdr_evt   = 1'b0;
        hdr_large = 1'b0;
        hdr_name  = dec_name;
        hdr_len   = dec_small_len;
        hdr_rsvd  = dec_rsvd;
        pay_evt   = 1'b0;
        if (accept) begin
            case (state_q)
                ST_TAG:     hdr_evt = !dec_large;
                ST_LEN_HI: begin
                    hdr_evt   = 1'b1;
                    hdr_large = 1'b1;
                    hdr_name  = name_q;
                    hdr_len   = wide_len;
                    hdr_rsvd  = rsvd_q;
                end
                ST_PAYLOAD: pay_evt = !rsvd_q;
                default:    pay_evt = 1'b0;
            endcase
        end
    end

    // State, counters and per-item context.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q  <= ST_TAG;
            rem_q    <= '0;
            off_q    <= '0;
            len_lo_q <= '0;
            name_q   <= '0;
            rsvd_q   <= 1'b0;
            end_q    <= 1'b0;
        end else if (accept) begin
            case (state_q)
                ST_TAG: begin
                    name_q <= dec_name;
                    rsvd_q <= dec_rsvd;
                    end_q  <= dec_end;
                    off_q  <= '0;
                    if (dec_large) begin
                        state_q <= ST_LEN_LO;
                    end else if (dec_small_len == '0) begin
                        state_q <= dec_end ? ST_DONE : ST_TAG;
                    end else begin
                        rem_q   <= dec_small_len;
                        state_q <= ST_PAYLOAD;
                    end
                end
                ST_LEN_LO: begin
                    len_lo_q <= in_data;
                    state_q  <= ST_LEN_HI;
                end
                ST_LEN_HI: begin
                    rem_q   <= wide_len;
                    state_q <= (wide_len == '0) ? ST_TAG : ST_PAYLOAD;
                end
                ST_PAYLOAD: begin
                    off_q <= off_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                    if (rem_q == LEN_W'(1)) begin
                        state_q <= end_q ? ST_DONE : ST_TAG;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/rsp_report.sv
// Module: rsp_report
// Output register stage: captures header fields and payload bytes on their
// events, drives the one-cycle strobes and keeps the sticky reserved flag.
// Assumes header and payload events never arrive in the same cycle.
module rsp_report
    import rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              hdr_evt,
    input  logic              hdr_large,
    input  logic [NAME_W-1:0] hdr_name,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              hdr_rsvd,
    input  logic              pay_evt,
    input  logic [BYTE_W-1:0] pay_byte,
    input  logic [LEN_W-1:0]  pay_off,
    output logic              item_start,
    output logic              item_large,
    output logic [NAME_W-1:0] item_name,
    output logic [LEN_W-1:0]  item_len,
    output logic              pay_valid,
    output logic [BYTE_W-1:0] pay_data,
    output logic [LEN_W-1:0]  pay_offset,
    output logic              rsvd_err
);
    // Register the header fields, the payload fields and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            item_start <= 1'b0;
            item_large <= 1'b0;
            item_name  <= '0;
            item_len   <= '0;
            pay_valid  <= 1'b0;
            pay_data   <= '0;
            pay_offset <= '0;
            rsvd_err   <= 1'b0;
        end else begin
            item_start <= hdr_evt;
            pay_valid  <= pay_evt;
            if (hdr_evt) begin
                item_large <= hdr_large;
                item_name  <= hdr_name;
                item_len   <= hdr_len;
                if (hdr_rsvd) begin
                    rsvd_err <= 1'b1;
                end
            end
            if (pay_evt) begin
                pay_data   <= pay_byte;
                pay_offset <= pay_off;
            end
        end
    end
endmodule

// File: rtl/res_stream_parser.sv
// Module: res_stream_parser
// Top level of the resource descriptor stream parser: tag decode, the parse
// state machine and the output register stage. It assumes a byte stream of
// small and large items that ends with a small end tag.
module res_stream_parser
    import rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              item_start,
    output logic              item_large,
    output logic [NAME_W-1:0] item_name,
    output logic [LEN_W-1:0]  item_len,
    output logic              pay_valid,
    output logic [BYTE_W-1:0] pay_data,
    output logic [LEN_W-1:0]  pay_offset,
    output logic              done,
    output logic              rsvd_err
);
    logic              dec_large, dec_end, dec_rsvd;
    logic [NAME_W-1:0] dec_name;
    logic [LEN_W-1:0]  dec_small_len;
    logic              hdr_evt, hdr_large, hdr_rsvd, pay_evt;
    logic [NAME_W-1:0] hdr_name;
    logic [LEN_W-1:0]  hdr_len, pay_off;
    logic [BYTE_W-1:0] pay_byte;

    rsp_tag_decode u_dec (
        .tag       (in_data),
        .is_large  (dec_large),
        .name      (dec_name),
        .small_len (dec_small_len),
        .is_end    (dec_end),
        .is_rsvd   (dec_rsvd)
    );

    rsp_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart       (restart),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .dec_large     (dec_large),
        .dec_name      (dec_name),
        .dec_small_len (dec_small_len),
        .dec_end       (dec_end),
        .dec_rsvd      (dec_rsvd),
        .in_ready      (in_ready),
        .hdr_evt       (hdr_evt),
        .hdr_large     (hdr_large),
        .hdr_name      (hdr_name),
        .hdr_len       (hdr_len),
        .hdr_rsvd      (hdr_rsvd),
        .pay_evt       (pay_evt),
        .pay_byte      (pay_byte),
        .pay_off       (pay_off),
        .done          (done)
    );

    rsp_report u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .hdr_evt    (hdr_evt),
        .hdr_large  (hdr_large),
        .hdr_name   (hdr_name),
        .hdr_len    (hdr_len),
        .hdr_rsvd   (hdr_rsvd),
        .pay_evt    (pay_evt),
        .pay_byte   (pay_byte),
        .pay_off    (pay_off),
        .item_start (item_start),
        .item_large (item_large),
        .item_name  (item_name),
        .item_len   (item_len),
        .pay_valid  (pay_valid),
        .pay_data   (pay_data),
        .pay_offset (pay_offset),
        .rsvd_err   (rsvd_err)
    );
endmodule

// File: rtl/rsp_checker.sv
// Module: rsp_checker
// Port-level properties of the parser, attached to every instance by bind.
module rsp_checker
    import rsp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              in_valid,
    input logic              in_ready,
    input logic              item_start,
    input logic              item_large,
    input logic [NAME_W-1:0] item_name,
    input logic              pay_valid,
    input logic              done,
    input logic              rsvd_err
);
    // R8: nothing is taken once the end tag is finished
    p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R8: done only leaves through restart
    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);

    // R6: the reserved flag is sticky
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsvd_err && !restart) |=> rsvd_err);

    // R6: a reserved small header shows the flag in its own cycle
    p_small_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (item_start && !item_large && item_name >= 7'h0A && item_name <= 7'h0D)
        |-> rsvd_err);

    // R9: restart clears the outputs
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!done && !rsvd_err && !item_start && !pay_valid));

    // R10: no event follows a cycle without input
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!item_start && !pay_valid));

    // R11: header and payload strobes are exclusive
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({item_start, pay_valid}));
endmodule

bind res_stream_parser rsp_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .item_start (item_start),
    .item_large (item_large),
    .item_name  (item_name),
    .pay_valid  (pay_valid),
    .done       (done),
    .rsvd_err   (rsvd_err)
);

// File: tb/res_stream_parser_tb_top.sv
// Bench: a behavioural reference model, updated on each rising edge and
// compared with every output a quarter period after that edge.
module res_stream_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, item_start, item_large, pay_valid, done, rsvd_err;
    logic [6:0]  item_name;
    logic [15:0] item_len, pay_offset;
    logic [7:0]  pay_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    res_stream_parser dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .item_start(item_start),
        .item_large(item_large), .item_name(item_name), .item_len(item_len),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_offset(pay_offset),
        .done(done), .rsvd_err(rsvd_err)
    );

    // Reference model state: 0 tag, 1 length low, 2 length high, 3 payload, 4 done
    int m_mode = 0, m_rem = 0, m_off = 0, m_lo = 0, m_name = 0;
    bit m_rsvd = 0, m_endi = 0;
    logic        e_start = 0, e_large = 0, e_pv = 0, e_err = 0;
    logic [6:0]  e_name = '0;
    logic [15:0] e_len = '0, e_po = '0;
    logic [7:0]  e_pd = '0;

    always @(posedge clk) begin
        e_start = 0;
        e_pv = 0;
        if (!rst_n || restart) begin
            m_mode = 0; m_rem = 0; m_off = 0; e_err = 0; e_large = 0;
            e_name = '0; e_len = '0; e_pd = '0; e_po = '0;
        end else if (in_valid && m_mode != 4) begin
            case (m_mode)
                0: if (in_data[7]) begin
                        m_name = int'(in_data[6:0]);
                        m_rsvd = (m_name < 1) || (m_name > 6);
                        m_endi = 0;
                        m_mode = 1;
                    end else begin
                        m_name = int'(in_data[6:3]);
                        m_rem  = int'(in_data[2:0]);
                        m_rsvd = (m_name >= 10) && (m_name <= 13);
                        m_endi = (m_name == 15);
                        m_off = 0;
                        e_start = 1; e_large = 0;
                        e_name = 7'(m_name); e_len = 16'(m_rem);
                        if (m_rsvd) e_err = 1;
                        if (m_rem == 0) m_mode = m_endi ? 4 : 0;
                        else m_mode = 3;
                    end
                1: begin m_lo = int'(in_data); m_mode = 2; end
                2: begin
                    m_rem = int'({in_data, 8'(m_lo)});
                    m_off = 0;
                    e_start = 1; e_large = 1;
                    e_name = 7'(m_name); e_len = 16'(m_rem);
                    if (m_rsvd) e_err = 1;
                    m_mode = (m_rem == 0) ? 0 : 3;
                end
                default: begin
                    if (!m_rsvd) begin
                        e_pv = 1; e_pd = in_data; e_po = 16'(m_off);
                    end
                    m_off = m_off + 1;
                    m_rem = m_rem - 1;
                    if (m_rem == 0) m_mode = m_endi ? 4 : 0;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison, a quarter period after each rising edge.
    bit run_cmp = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        #5;
        if (run_cmp) begin
            logic e_ready;
            e_ready = (m_mode != 4) && !restart;
            chk(in_ready === e_ready, "R8 R9 R10 in_ready", int'(in_ready), int'(e_ready));
            chk(item_start === e_start, "R2 R3 R5 item_start", int'(item_start), int'(e_start));
            chk(item_large === e_large, "R2 R3 item_large", int'(item_large), int'(e_large));
            chk(item_name === e_name, "R2 R3 item_name", int'(item_name), int'(e_name));
            chk(item_len === e_len, "R2 R3 item_len", int'(item_len), int'(e_len));
            chk(pay_valid === e_pv, "R4 R6 R10 pay_valid", int'(pay_valid), int'(e_pv));
            chk(pay_data === e_pd, "R4 pay_data", int'(pay_data), int'(e_pd));
            chk(pay_offset === e_po, "R4 pay_offset", int'(pay_offset), int'(e_po));
            chk(done === (m_mode == 4), "R7 R8 R9 done", int'(done), int'(m_mode == 4));
            chk(rsvd_err === e_err, "R6 R9 rsvd_err", int'(rsvd_err), int'(e_err));
            chk(!(item_start && pay_valid), "R11 strobe overlap",
                int'({item_start, pay_valid}), 0);
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        in_valid = 1'b1;     // R9: this byte must not be consumed
        in_data = 8'h22;
        @(negedge clk);
        restart = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #6;
        // R1: reset state
        chk(!done && !rsvd_err && !item_start && !pay_valid && in_ready &&
            item_len == 0 && pay_offset == 0, "R1 reset state",
            int'({done, rsvd_err, item_start, pay_valid, in_ready}), 1);
        run_cmp = 1;
        // R2 R4: small item, name 4, two bytes
        put(8'h22); put(8'hAB); put(8'hCD);
        // R5: zero-length small item followed at once by another tag
        put(8'h30); put(8'h11); put(8'h5E);
        // R3 R10: large item, name 1, three bytes, with idle gaps
        put(8'h81); idle(2); put(8'h03); idle(1); put(8'h00);
        put(8'h01); idle(3); put(8'h02); put(8'h03);
        // R5: zero-length large item
        put(8'h82); put(8'h00); put(8'h00);
        // R6: reserved small name 0xB, two bytes skipped
        put(8'h5A); put(8'hEE); put(8'hEF);
        // R6: reserved large name 0x7F, one byte skipped
        put(8'hFF); put(8'h01); put(8'h00); put(8'h99);
        // R7: end tag with one checksum byte, then R8 ignored input
        put(8'h79); put(8'h55);
        put(8'h22); put(8'h44); idle(3);
        // R9: restart, then zero-length end tag
        do_restart();
        put(8'h78); idle(2);
        do_restart();
        // long large item, name 4, 0x0102 bytes
        put(8'h84); put(8'h02); put(8'h01);
        for (int i = 0; i < 258; i++) put(8'(i * 7));
        // reset in the middle of an item
        put(8'h23); put(8'h01);
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        put(8'h0A); put(8'h77); put(8'h66);
        put(8'h79); put(8'hA5); idle(4);
        run_cmp = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule